// File: doc/BRIEF.md
# Greater-Than Compare Stage with Early-Decision Input Hold

This block is one registered pipeline stage that decides whether operand `a_in` is larger than operand `b_in`, both unsigned `N`-bit values. A result leaves the output flop two clock edges after its operands are presented, and a new pair may be presented every cycle.

A cheap early look at the top `PW` bits of the incoming operands often settles the answer on its own. When the top field of `a_in` is strictly above that of `b_in`, the answer must be 1. When it is strictly below, the answer must be 0. In either case the operand register keeps its old contents for one cycle, so the wide comparator sees no toggling inputs. The early verdict travels through its own pair of flip-flops and overrides the comparator result through an AND-OR gate in front of the output flop. While that override is in force the comparator output is unused, so its value does not matter. When the top fields are equal, the operands are loaded and the full comparison decides.

The stage is intended to sit between two pipeline registers of a larger datapath. The power saving comes from inputs that do not switch, and the latency and throughput are the same as those of a plain registered comparator.

Top module: `gt_precomp_stage`

## Requirements
- R1: For every operand pair presented at a rising edge, the value of `gt_out` after the second following rising edge equals 1 exactly when `a_in > b_in` as unsigned numbers.
- R2: If the top `PW` bits of `a_in` (bits N-1 down to N-PW, unsigned) exceed those of `b_in`, the result for that pair is 1, whatever the operand register holds at that time.
- R3: If the top `PW` bits of `a_in` are below those of `b_in`, the result for that pair is 0, whatever the operand register holds at that time.
- R4: If the top `PW` bits of both operands are equal, the result comes from the full-width comparison of the loaded operands; equal operands give 0.
- R5: The early "greater" verdict is raised only for pairs where `a_in > b_in` holds. The early "not greater" verdict is raised only for pairs where it does not hold. The two verdicts are never raised together.
- R6: In the cycle after either early verdict is raised, the operand register holds the value it had before.
- R7: While `rst` is high at a rising edge, the operand register, both verdict flops and `gt_out` are cleared to 0. The output stays 0 on the first edge after `rst` is released.
- R8: Results are produced at one per cycle for any mix of early-decided and fully compared pairs, including runs of consecutive early decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | N | First unsigned operand |
| b_in | input | N | Second unsigned operand |
| gt_out | output | 1 | Registered result: 1 when `a_in > b_in`, two edges late |

## Verification
The hardest case to reach is a pair decided early while the held operand register contains an older pair whose full comparison gives the opposite answer. Only in that case does a missing override or a wrong polarity show at the output. The directed table places a fully compared pair that yields 1 directly before a top-field "less" pair, and does the same with the polarities swapped. It also chains early decisions back to back, so that the operand register stays frozen over several cycles while the verdict flops alternate. A long run of random operands then mixes all three paths, and a reset inside the stream checks that stale operands do not leak out after the release.

// File: rtl/gt_precomp_stage.sv
module gt_precomp_stage #(
  parameter int N  = 8,
  parameter int PW = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] b_in,
  output logic         gt_out
);

  localparam int PLO = N - PW;

  logic [N-1:0] a_q, b_q;
  logic         hi_q, lo_q;
  logic         hi_c, lo_c, load, f_gt, nxt;

  // early verdicts on the incoming top field
  assign hi_c = a_in[N-1:PLO] > b_in[N-1:PLO];
  assign lo_c = a_in[N-1:PLO] < b_in[N-1:PLO];
  assign load = ~(hi_c | lo_c);

  // wide comparator; its value is unused whenever a verdict flop is set
  assign f_gt = a_q > b_q;
  assign nxt  = hi_q | (f_gt & ~lo_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      gt_out <= 1'b0;
    end else begin
      if (load) begin
        a_q <= a_in;
        b_q <= b_in;
      end
      hi_q   <= hi_c;
      lo_q   <= lo_c;
      gt_out <= nxt;
    end
  end

  p_verdict_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(hi_q && lo_q));

  p_hi_sound_r5: assert property (@(posedge clk) disable iff (rst)
    hi_c |-> (a_in > b_in));

  p_lo_sound_r5: assert property (@(posedge clk) disable iff (rst)
    lo_c |-> !(a_in > b_in));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (hi_c || lo_c) |=> ($stable(a_q) && $stable(b_q)));

  p_force_one_r2: assert property (@(posedge clk) disable iff (rst)
    hi_q |=> gt_out);

  p_force_zero_r3: assert property (@(posedge clk) disable iff (rst)
    lo_q |=> !gt_out);

  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> (!gt_out && !hi_q && !lo_q && a_q == '0 && b_q == '0));

endmodule

// File: tb/test_gt_precomp_stage.sv
`timescale 1ns/1ps
module test_gt_precomp_stage;

  localparam int NV = 16;
  localparam logic [7:0] VA [NV] = '{8'h10, 8'h00, 8'h35, 8'hC0, 8'h3F, 8'h7F, 8'h80, 8'h81,
                                     8'h40, 8'h41, 8'hFF, 8'hFF, 8'hFE, 8'h00, 8'h01, 8'h00};
  localparam logic [7:0] VB [NV] = '{8'h05, 8'hC0, 8'h34, 8'h3F, 8'hC0, 8'h7F, 8'h7F, 8'h80,
                                     8'hFF, 8'h7F, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h01};
  localparam bit         VE [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1,
                                     1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a_in = '0, b_in = '0;
  logic       gt_out;

  int    n_chk = 0, n_fail = 0;
  bit    e1 = 0, e2 = 0, v1 = 0, v2 = 0, lr = 1;
  string t1 = "", t2 = "";

  gt_precomp_stage #(.N(8), .PW(2)) i_gt_precomp_stage (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .gt_out(gt_out));

  always #4 clk = ~clk;

  function automatic string tag_of(input logic [7:0] a, input logic [7:0] b);
    if (a[7:6] > b[7:6]) return "R2 R5 R6";
    if (a[7:6] < b[7:6]) return "R3 R5 R6";
    return "R4 R1";
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: gt_out=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a falling edge: check the pair from two steps back, then drive the next pair
  task automatic step(input logic [7:0] a, input logic [7:0] b, input bit r, input bit ex,
                      input string tag);
    if (lr) check(gt_out, 1'b0, "R7");
    else if (v2) check(gt_out, e2, t2);
    e2 = e1; t2 = t1; v2 = v1;
    e1 = r ? 1'b0 : ex;
    t1 = r ? "R7" : tag;
    v1 = 1'b1;
    lr = r;
    a_in = a; b_in = b; rst = r;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(8'hAA, 8'h11, 1'b1, 1'b0, "R7");
    check(gt_out, 1'b0, "R7 reset state");

    for (int i = 0; i < NV; i++) step(VA[i], VB[i], 1'b0, VE[i], tag_of(VA[i], VB[i]));

    // frozen register holds a pair whose full comparison disagrees with the verdict
    step(8'h3E, 8'h01, 1'b0, 1'b1, "R4");
    step(8'h00, 8'hFF, 1'b0, 1'b0, "R3 R6 stale greater");
    step(8'h02, 8'h30, 1'b0, 1'b0, "R4");
    step(8'hC1, 8'h02, 1'b0, 1'b1, "R2 R6 stale less");

    // run of consecutive early decisions
    for (int i = 0; i < 10; i++) begin
      logic [7:0] a = (i % 2 == 0) ? 8'hC3 : 8'h12;
      logic [7:0] b = (i % 2 == 0) ? 8'h5A : 8'h99;
      step(a, b, 1'b0, a > b, "R8");
    end

    // reset in the middle of a stream, stale operands must not leak
    step(8'h3F, 8'h00, 1'b0, 1'b1, "R4");
    step(8'h3F, 8'h00, 1'b1, 1'b0, "R7");
    step(8'h80, 8'h00, 1'b0, 1'b1, "R7 R2");
    step(8'h01, 8'h00, 1'b0, 1'b1, "R4");

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a = 8'($urandom);
      logic [7:0] b = (i % 3 == 0) ? {a[7:6], 6'($urandom)} : 8'($urandom);
      step(a, b, 1'b0, a > b, {"R1 R8 ", tag_of(a, b)});
    end
    step(8'h00, 8'h00, 1'b0, 1'b0, "R1");
    step(8'h00, 8'h00, 1'b0, 1'b0, "R1");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule